// File: doc/BRIEF.md
# Dual-Port Ethernet Interrupt Controller

This block gathers interrupt events from two Ethernet ports and merges them into one level-sensitive interrupt line toward the processor. Each port owns a 32-bit cause register and a 32-bit mask register. Single-cycle event pulses from the transmit and receive engines set bits in the cause register. Software clears bits through a write that ANDs the written value into the cause register, so any bit written as 0 is cleared and any bit written as 1 is kept.

Bit 31 of each cause register is a summary flag. On every clock edge it is recomputed from the new cause and mask values, using only cause bits 30 to 0. The interrupt output is high while any port's summary flag is set. A separate system status word returns one summary flag per port, so a handler can see at once which port needs service.

The register interface is a plain strobe interface. The read data is combinational from the address while the read strobe is high, and a write takes effect at the next rising clock edge. There is no back-pressure: every access completes in the cycle it is presented. Reads have no side effects.

Top module: `eth_irq_ctrl`

## Requirements
- R1: Port 0 has its cause register at 0x84850 and its mask register at 0x84858. Port 1 has its cause register at 0x88850 and its mask register at 0x88858. A read of any of these returns the register's current value.
- R2: A write to a cause register replaces bits 30:0 with (old value AND write data) at the next clock edge.
- R3: A write to a mask register loads all 32 bits of the write data at the next clock edge.
- R4: Cause bit 31 is the port summary. After every edge it equals the OR over bits 30:0 of (cause AND mask).
- R5: irq_o is high exactly when at least one port's summary bit is set.
- R6: A read at 0x00C18 returns the summary of port p in bit p (bit 0 for port 0, bit 1 for port 1). All other bits read zero.
- R7: Event pulses set cause bits at the next edge: ev_rx sets bit 0, ev_tx_done sets bit 2 and ev_tx_abort sets bit 12.
- R8: When an event pulse and a cause write that clears the same bit arrive in the same cycle, the bit ends up set.
- R9: Mask bit 31 and a stale summary bit cannot keep the summary or irq_o asserted when (cause AND mask) over bits 30:0 is zero.
- R10: Reads change no register and do not change irq_o.
- R11: Reset clears every cause and mask bit and drives irq_o low.
- R12: A read of an address that is not decoded returns zero. A write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_wr | input | 1 | Write strobe |
| acc_rd | input | 1 | Read strobe |
| acc_addr | input | 20 | Register byte offset |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational, zero when acc_rd is low |
| ev_rx | input | 2 | Per-port receive event pulse |
| ev_tx_done | input | 2 | Per-port transmit-complete pulse |
| ev_tx_abort | input | 2 | Per-port transmit-underrun pulse |
| irq_o | output | 1 | Shared level interrupt |

## Verification
The bench targets the following corner cases:

- **Set against clear in one cycle.** An event pulse arrives in the same cycle as a cause write that clears the same bit. A design where the clear wins would lose the event and leave irq_o low.
- **Mask bit 31 set, no real overlap.** Mask bit 31 is set while the real cause bits do not overlap the mask. A design that includes the summary bit in its own calculation would latch the interrupt high forever.
- **Undecoded offsets.** Writes go to the address one word off a cause register. A loose decoder would corrupt a register.
- **Mask clears a pending interrupt.** A mask write removes a pending interrupt. A design that recomputes the summary only on events would keep irq_o asserted.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int unsigned DW          = 32;
  localparam int unsigned SUM_BIT     = 31;
  localparam int unsigned RX_BIT      = 0;
  localparam int unsigned TXDONE_BIT  = 2;
  localparam int unsigned TXUDR_BIT   = 12;

  typedef logic [DW-1:0] word_t;

  // cause bits that may feed the summary: everything except the summary itself
  localparam word_t FIELD_MASK = ~(word_t'(1) << SUM_BIT);

  function automatic word_t event_bits(input logic rx, input logic done, input logic abort);
    word_t v;
    v = '0;
    v[RX_BIT]     = rx;
    v[TXDONE_BIT] = done;
    v[TXUDR_BIT]  = abort;
    return v;
  endfunction
endpackage

// File: rtl/eic_addr_decode.sv
module eic_addr_decode #(
  parameter int unsigned NUM_PORTS   = 2,
  parameter int unsigned AW          = 20,
  parameter int unsigned PORT_BASE   = 32'h80000,
  parameter int unsigned PORT_STRIDE = 32'h04000,
  parameter int unsigned CAUSE_OFF   = 32'h00850,
  parameter int unsigned MASK_OFF    = 32'h00858,
  parameter int unsigned STAT_ADDR   = 32'h00C18
) (
  input  logic [AW-1:0]        addr,
  output logic [NUM_PORTS-1:0] cause_hit,
  output logic [NUM_PORTS-1:0] mask_hit,
  output logic                 stat_hit
);
  localparam logic [AW-1:0] STAT_A = AW'(STAT_ADDR);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [AW-1:0] CAUSE_A = AW'(PORT_BASE + (p + 1) * PORT_STRIDE + CAUSE_OFF);
    localparam logic [AW-1:0] MASK_A  = AW'(PORT_BASE + (p + 1) * PORT_STRIDE + MASK_OFF);
    assign cause_hit[p] = (addr == CAUSE_A);
    assign mask_hit[p]  = (addr == MASK_A);
  end

  assign stat_hit = (addr == STAT_A);
endmodule

// File: rtl/eic_port_regs.sv
module eic_port_regs
  import eic_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_cause,
  input  logic  wr_mask,
  input  word_t wdata,
  input  word_t ev_bits,
  output word_t cause_q,
  output word_t mask_q,
  output logic  sum_o
);
  word_t cause_base, cause_next, mask_next;
  logic  sum_next;

  always_comb begin
    cause_base = wr_cause ? (cause_q & wdata) : cause_q;
    // events OR in after the clear so a coincident set survives
    cause_next = (cause_base | ev_bits) & FIELD_MASK;
    mask_next  = wr_mask ? wdata : mask_q;
    sum_next   = |(cause_next & mask_next & FIELD_MASK);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '0;
    end else begin
      cause_q <= cause_next | (word_t'(sum_next) << SUM_BIT);
      mask_q  <= mask_next;
    end
  end

  assign sum_o = cause_q[SUM_BIT];

  assert_and_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cause && ev_bits == '0) |=> ((cause_q & FIELD_MASK) == ($past(cause_q & wdata) & FIELD_MASK)));

  assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == $past(wdata)));

  // R4 and R9: summary tracks only the real cause field
  assert_summary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (cause_q[SUM_BIT] == |(cause_q & mask_q & FIELD_MASK)));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_bits & FIELD_MASK) != '0) |=> ((cause_q & $past(ev_bits & FIELD_MASK)) == $past(ev_bits & FIELD_MASK)));
endmodule

// File: rtl/eic_rd_mux.sv
module eic_rd_mux
  import eic_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 2
) (
  input  logic                        rd_en,
  input  logic [NUM_PORTS-1:0]        cause_hit,
  input  logic [NUM_PORTS-1:0]        mask_hit,
  input  logic                        stat_hit,
  input  logic [NUM_PORTS-1:0][DW-1:0] cause_v,
  input  logic [NUM_PORTS-1:0][DW-1:0] mask_v,
  input  logic [NUM_PORTS-1:0]        sums,
  output word_t                       rdata
);
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (cause_hit[p]) rdata = cause_v[p];
        if (mask_hit[p])  rdata = mask_v[p];
      end
      if (stat_hit) rdata[NUM_PORTS-1:0] = sums;
    end
  end

  always_comb begin
    if (rd_en && stat_hit)
      assert_stat_upper_zero_R6: assert ((rdata >> NUM_PORTS) == '0);
    if (!(rd_en && (stat_hit || (|cause_hit) || (|mask_hit))))
      assert_undecoded_zero_R12: assert (rdata == '0);
  end
endmodule

// File: rtl/eth_irq_ctrl.sv
module eth_irq_ctrl
  import eic_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = 2,
  parameter int unsigned AW          = 20,
  parameter int unsigned PORT_BASE   = 32'h80000,
  parameter int unsigned PORT_STRIDE = 32'h04000,
  parameter int unsigned CAUSE_OFF   = 32'h00850,
  parameter int unsigned MASK_OFF    = 32'h00858,
  parameter int unsigned STAT_ADDR   = 32'h00C18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_wr,
  input  logic                 acc_rd,
  input  logic [AW-1:0]        acc_addr,
  input  logic [31:0]          acc_wdata,
  output logic [31:0]          acc_rdata,
  input  logic [NUM_PORTS-1:0] ev_rx,
  input  logic [NUM_PORTS-1:0] ev_tx_done,
  input  logic [NUM_PORTS-1:0] ev_tx_abort,
  output logic                 irq_o
);
  logic [NUM_PORTS-1:0]         cause_hit, mask_hit, sums;
  logic                         stat_hit;
  logic [NUM_PORTS-1:0][DW-1:0] cause_v, mask_v;

  eic_addr_decode #(
    .NUM_PORTS(NUM_PORTS), .AW(AW), .PORT_BASE(PORT_BASE), .PORT_STRIDE(PORT_STRIDE),
    .CAUSE_OFF(CAUSE_OFF), .MASK_OFF(MASK_OFF), .STAT_ADDR(STAT_ADDR)
  ) u_dec (
    .addr(acc_addr), .cause_hit(cause_hit), .mask_hit(mask_hit), .stat_hit(stat_hit)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    eic_port_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_cause(acc_wr && cause_hit[p]),
      .wr_mask (acc_wr && mask_hit[p]),
      .wdata   (acc_wdata),
      .ev_bits (event_bits(ev_rx[p], ev_tx_done[p], ev_tx_abort[p])),
      .cause_q (cause_v[p]),
      .mask_q  (mask_v[p]),
      .sum_o   (sums[p])
    );
  end

  eic_rd_mux #(.NUM_PORTS(NUM_PORTS)) u_rd (
    .rd_en(acc_rd), .cause_hit(cause_hit), .mask_hit(mask_hit), .stat_hit(stat_hit),
    .cause_v(cause_v), .mask_v(mask_v), .sums(sums), .rdata(acc_rdata)
  );

  assign irq_o = |sums;

  // cross-check the line against the raw register contents
  logic any_pending;
  always_comb begin
    any_pending = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++)
      any_pending = any_pending | (|(cause_v[p] & mask_v[p] & FIELD_MASK));
  end

  assert_irq_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (irq_o == any_pending));

  assert_reset_clear_R11: assert property (@(posedge clk)
    $past(!rst_n) |-> (!irq_o && cause_v == '0 && mask_v == '0));
endmodule

// File: tb/eth_irq_ctrl_bench.sv
`timescale 1ns/10ps
module eth_irq_ctrl_bench;
  localparam logic [19:0] C0 = 20'h84850, C1 = 20'h88850;
  localparam logic [19:0] M0 = 20'h84858, M1 = 20'h88858;
  localparam logic [19:0] ST = 20'h00C18, BAD = 20'h84854;

  logic clk = 0, rst_n = 0, acc_wr = 0, acc_rd = 0;
  logic [19:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0, acc_rdata;
  logic [1:0] ev_rx = 0, ev_tx_done = 0, ev_tx_abort = 0;
  logic irq_o;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_cause [2];
  logic [31:0] m_mask [2];

  always #2.5 clk = ~clk;

  eth_irq_ctrl u_eth_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .ev_rx(ev_rx), .ev_tx_done(ev_tx_done),
    .ev_tx_abort(ev_tx_abort), .irq_o(irq_o)
  );

  function automatic logic exp_sum(int p);
    return |(m_cause[p] & m_mask[p] & 32'h7FFF_FFFF);
  endfunction

  function automatic logic [31:0] exp_cause(int p);
    return (m_cause[p] & 32'h7FFF_FFFF) | {exp_sum(p), 31'b0};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [19:0] a, output logic [31:0] d);
    acc_addr = a; acc_rd = 1; #0.2;
    d = acc_rdata; acc_rd = 0; #0.1;
  endtask

  task automatic check_all(string req);
    logic [31:0] d;
    rd(C0, d); chk(req, "cause0", d, exp_cause(0));
    rd(C1, d); chk(req, "cause1", d, exp_cause(1));
    rd(M0, d); chk(req, "mask0", d, m_mask[0]);
    rd(M1, d); chk(req, "mask1", d, m_mask[1]);
    rd(ST, d); chk(req, "status", d, {30'b0, exp_sum(1), exp_sum(0)});
    chk(req, "irq", {31'b0, irq_o}, {31'b0, exp_sum(0) | exp_sum(1)});
  endtask

  // one clocked access plus event pulses; model updated at the edge
  task automatic step(logic wr, logic [19:0] a, logic [31:0] wd,
                      logic [1:0] rx, logic [1:0] td, logic [1:0] ta);
    @(negedge clk);
    acc_wr = wr; acc_addr = a; acc_wdata = wd;
    ev_rx = rx; ev_tx_done = td; ev_tx_abort = ta;
    @(posedge clk);
    for (int p = 0; p < 2; p++) begin
      if (wr && a == (p == 0 ? C0 : C1)) m_cause[p] = m_cause[p] & wd;
      if (wr && a == (p == 0 ? M0 : M1)) m_mask[p] = wd;
      m_cause[p] = (m_cause[p] | {19'b0, ta[p], 9'b0, td[p], 1'b0, rx[p]}) & 32'h7FFF_FFFF;
    end
    #0.2;
    acc_wr = 0; ev_rx = 0; ev_tx_done = 0; ev_tx_abort = 0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(posedge clk);
    #0.2; rst_n = 1;
    for (int p = 0; p < 2; p++) begin m_cause[p] = 0; m_mask[p] = 0; end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    void'($urandom(32'd20240611));
    do_reset();
    check_all("R11");

    // R7 event bit positions
    step(0, '0, '0, 2'b01, 2'b00, 2'b00);
    rd(C0, d); chk("R7", "rx bit0", d, 32'h1);
    step(0, '0, '0, 2'b00, 2'b10, 2'b10);
    rd(C1, d); chk("R7", "txdone bit2 txudr bit12", d, 32'h1004);
    chk("R5", "irq masked off", {31'b0, irq_o}, 32'h0);
    // R3 and R4: unmasking raises summary and irq
    step(1, M1, 32'h0000_1000, 0, 0, 0);
    check_all("R4");
    rd(ST, d); chk("R6", "status port1", d, 32'h2);
    // R2: clear bit12 on port 1, keep bit2
    step(1, C1, 32'hFFFF_EFFF, 0, 0, 0);
    rd(C1, d); chk("R2", "and-clear", d, 32'h4);
    chk("R5", "irq falls", {31'b0, irq_o}, 32'h0);
    // R8: coincident clear and set of bit2 on port 0
    step(1, M0, 32'h0000_0004, 0, 0, 0);
    step(1, C0, 32'h0, 0, 2'b01, 0);
    rd(C0, d); chk("R8", "set wins", d, 32'h8000_0004);
    chk("R8", "irq", {31'b0, irq_o}, 32'h1);
    // R9: mask bit 31 alone does not sustain summary
    step(1, M0, 32'h8000_0000, 0, 0, 0);
    rd(C0, d); chk("R9", "summary self-hold", d, 32'h4);
    chk("R9", "irq", {31'b0, irq_o}, 32'h0);
    step(1, C0, 32'hFFFF_FFFF, 0, 0, 0);
    check_all("R9");
    // R10: repeated reads have no effect
    step(1, M0, 32'hFFFF_FFFF, 0, 0, 0);
    rd(C0, d); rd(C0, d2);
    chk("R10", "read stable", d2, d);
    @(negedge clk);
    check_all("R10");
    // R12: undecoded write ignored, read zero
    step(1, BAD, 32'h0, 0, 0, 0);
    check_all("R12");
    rd(BAD, d); chk("R12", "undecoded read", d, 32'h0);
    // R1 random traffic
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [19:0] a;
      logic [31:0] wd;
      op = $urandom % 8;
      wd = $urandom;
      case (op)
        0: a = C0; 1: a = C1; 2: a = M0; 3: a = M1; 4: a = BAD; default: a = ST;
      endcase
      if (op < 2 && ($urandom % 2)) wd = wd | $urandom;
      step(op < 6, a, wd, 2'($urandom % 4 == 0 ? $urandom : 0),
           2'($urandom % 4 == 0 ? $urandom : 0), 2'($urandom % 5 == 0 ? $urandom : 0));
      check_all("R1");
      if (i == 300) begin
        do_reset();
        check_all("R11");
      end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule